// File: doc/BRIEF.md
# Sample Word Format Converter

This block turns one wide two's-complement sample into the word a serial output stage sends. A three-bit select chooses the format. There are five fixed-point and float formats: an 8-bit word truncated from the top of the sample, 16-bit and 24-bit words rounded with saturation, a full 32-bit word, and a compact 12-bit floating-point code. The float code has an 8-bit two's-complement mantissa and a 4-bit shift count, which gives about 138 dB of range in 12 bits.

The result is always placed at the top of a 32-bit field, MSB first, with zeros below it. A length output tells the downstream serializer how many of the leading bits to shift out. The result is registered, so output valid follows input valid one cycle later. The output word and length hold their values between valid samples.

Top module: `sfc_top`

## Requirements
- R1: While reset is asserted (rst_n low), o_vld, o_word and o_len are all zero.
- R2: o_vld equals the i_vld of the previous clock edge. o_word and o_len load only on edges where i_vld is high and hold their values otherwise.
- R3: The format codes and lengths are: i_fmt 0 gives 8 bits, 1 gives 16, 2 gives 24, 3 gives 32, and 4 gives 12 (float). Codes 5, 6 and 7 act exactly like code 3.
- R4: In the 8-bit format, o_word[31:24] = i_sample[31:24] and o_word[23:0] = 0.
- R5: In the W-bit rounded formats (W = 16 or 24), the top W bits of o_word are floor((s + 2^(31-W)) / 2^(32-W)), where s is the signed sample. The lower bits are zero.
- R6: When that rounded value exceeds 2^(W-1)-1, the output instead holds 2^(W-1)-1 (0x7FFF or 0x7FFFFF). A rounded result never changes sign.
- R7: In the 32-bit format, o_word equals i_sample.
- R8: In the float format, the exponent e is the largest shift from 0 to 15 for which s·2^e still fits in 32 signed bits. The mantissa is bits [31:24] of s·2^e. o_word[31:24] holds the mantissa, o_word[23:20] holds e, and o_word[19:0] is zero.
- R9: A sample with 16 or more redundant sign bits, including 0 and -1, is given exponent 15. Its mantissa is then taken without full normalization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_vld | input | 1 | Input sample qualifier |
| i_sample | input | 32 | Two's-complement input sample |
| i_fmt | input | 3 | Format select code |
| o_vld | output | 1 | Output word qualifier |
| o_word | output | 32 | Left-justified result field |
| o_len | output | 6 | Number of leading bits of o_word to send |

## Verification
Two functions can fall in the same cycle: the rounding carry and saturation. The half-LSB add carries into the sign position, and the clamp must take over in that same cycle. This is provoked with samples just below positive full scale, from 0x7FFF0000 up to 0x7FFFFFFF, and with the exact tie points around them. The result is judged against rounding done in 64-bit integer arithmetic in the bench. Format changes on every consecutive valid cycle are also driven, so that a stale select or length would show up on the next word.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
   localparam int unsigned FIELD_W = 32;
   localparam int unsigned LEN_W   = 6;

   typedef enum logic [2:0] {
      FMT_T8   = 3'd0,
      FMT_R16  = 3'd1,
      FMT_R24  = 3'd2,
      FMT_T32  = 3'd3,
      FMT_FL12 = 3'd4
   } fmt_e;

   localparam logic [LEN_W-1:0] LEN_T8   = 6'd8;
   localparam logic [LEN_W-1:0] LEN_R16  = 6'd16;
   localparam logic [LEN_W-1:0] LEN_R24  = 6'd24;
   localparam logic [LEN_W-1:0] LEN_T32  = 6'd32;
   localparam logic [LEN_W-1:0] LEN_FL12 = 6'd12;
endpackage

// File: rtl/sfc_round.sv
module sfc_round #(
   parameter int unsigned IN_W     = 32,
   parameter int unsigned RES_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic [IN_W-1:0]  x,
   output logic [RES_W-1:0] r
);
   localparam int unsigned HALF_POS = IN_W - RES_W - 1;

   if (RES_W < 2 || RES_W >= IN_W) begin : g_bad_w
      $error("sfc_round: RES_W must lie between 2 and IN_W-1");
   end

   logic [IN_W:0]  half_c;
   logic [IN_W:0]  sum;
   logic [RES_W:0] top;
   logic           ovf;

   assign half_c = (IN_W+1)'(1) << HALF_POS;
   assign sum    = {x[IN_W-1], x} + half_c;
   assign top    = sum[IN_W -: RES_W+1];
   assign ovf    = top[RES_W] ^ top[RES_W-1];

   if (SATURATE) begin : g_sat
      assign r = ovf ? {1'b0, {(RES_W-1){1'b1}}} : top[RES_W-1:0];
   end else begin : g_wrap
      assign r = top[RES_W-1:0];
   end

   always_comb begin
      if (SATURATE && (x[IN_W-1] == 1'b0))
         AST_NO_OVERFLOW: assert (r[RES_W-1] == 1'b0); // R6
   end
endmodule

// File: rtl/sfc_float.sv
module sfc_float #(
   parameter int unsigned IN_W   = 32,
   parameter int unsigned MANT_W = 8,
   parameter int unsigned EXP_W  = 4
) (
   input  logic [IN_W-1:0]   x,
   output logic [MANT_W-1:0] mant,
   output logic [EXP_W-1:0]  expo
);
   localparam int unsigned MAX_SH = (1 << EXP_W) - 1;

   if (MAX_SH + MANT_W > IN_W) begin : g_bad_w
      $error("sfc_float: shift range plus mantissa exceeds the sample width");
   end

   logic [IN_W-1:0]  shifted;
   logic [EXP_W-1:0] cnt;

   always_comb begin
      logic done;
      cnt  = '0;
      done = 1'b0;
      for (int i = 1; i <= MAX_SH; i++) begin
         if (!done && (x[IN_W-1-i] == x[IN_W-1]))
            cnt = cnt + EXP_W'(1);
         else
            done = 1'b1;
      end
   end

   assign shifted = x << cnt;
   assign mant    = shifted[IN_W-1 -: MANT_W];
   assign expo    = cnt;

   always_comb begin
      if (expo != EXP_W'(MAX_SH))
         AST_FLOAT_NORM: assert (mant[MANT_W-1] != mant[MANT_W-2]); // R8
      AST_FLOAT_SIGN: assert (mant[MANT_W-1] == x[IN_W-1]); // R8
   end
endmodule

// File: rtl/sfc_top.sv
module sfc_top
   import sfc_pkg::*;
#(
   parameter int unsigned IN_W   = 32,
   parameter int unsigned MANT_W = 8,
   parameter int unsigned EXP_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              i_vld,
   input  logic [IN_W-1:0]   i_sample,
   input  logic [2:0]        i_fmt,
   output logic              o_vld,
   output logic [FIELD_W-1:0] o_word,
   output logic [LEN_W-1:0]  o_len
);
   localparam int unsigned FL_W = MANT_W + EXP_W;

   if (IN_W < FIELD_W) begin : g_bad_in
      $error("sfc_top: IN_W must be at least the 32-bit field width");
   end
   if (FL_W > FIELD_W) begin : g_bad_fl
      $error("sfc_top: float code wider than the field");
   end

   logic [15:0]        r16;
   logic [23:0]        r24;
   logic [MANT_W-1:0]  fl_mant;
   logic [EXP_W-1:0]   fl_exp;
   logic [FIELD_W-1:0] nxt_word;
   logic [LEN_W-1:0]   nxt_len;
   fmt_e               fsel;

   sfc_round #(.IN_W(IN_W), .RES_W(16), .SATURATE(1'b1)) u_r16 (.x(i_sample), .r(r16));
   sfc_round #(.IN_W(IN_W), .RES_W(24), .SATURATE(1'b1)) u_r24 (.x(i_sample), .r(r24));
   sfc_float #(.IN_W(IN_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_fl (
      .x(i_sample), .mant(fl_mant), .expo(fl_exp));

   assign fsel = fmt_e'(i_fmt);

   always_comb begin
      case (fsel)
         FMT_T8: begin
            nxt_word = {i_sample[IN_W-1 -: 8], 24'd0};
            nxt_len  = LEN_T8;
         end
         FMT_R16: begin
            nxt_word = {r16, 16'd0};
            nxt_len  = LEN_R16;
         end
         FMT_R24: begin
            nxt_word = {r24, 8'd0};
            nxt_len  = LEN_R24;
         end
         FMT_FL12: begin
            nxt_word = {fl_mant, fl_exp, {(FIELD_W-FL_W){1'b0}}};
            nxt_len  = LEN_FL12;
         end
         default: begin
            nxt_word = i_sample[IN_W-1 -: FIELD_W];
            nxt_len  = LEN_T32;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_vld  <= 1'b0;
         o_word <= '0;
         o_len  <= '0;
      end else begin
         o_vld <= i_vld;
         if (i_vld) begin
            o_word <= nxt_word;
            o_len  <= nxt_len;
         end
      end
   end

   AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      i_vld |=> o_vld); // R2
   AST_VLD_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !i_vld |=> !o_vld); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !i_vld |=> ($stable(o_word) && $stable(o_len))); // R2
   AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      o_vld |-> (o_len == LEN_T8 || o_len == LEN_R16 || o_len == LEN_R24 ||
                 o_len == LEN_T32 || o_len == LEN_FL12)); // R3
   AST_PAD_T8: assert property (@(posedge clk) disable iff (!rst_n)
      (o_vld && o_len == LEN_T8) |-> (o_word[23:0] == 24'd0)); // R4
   AST_PAD_FL: assert property (@(posedge clk) disable iff (!rst_n)
      (o_vld && o_len == LEN_FL12) |-> (o_word[FIELD_W-FL_W-1:0] == '0)); // R8
endmodule

// File: tb/sfc_top_test.sv
module sfc_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        i_vld = 1'b0;
   logic [31:0] i_sample = '0;
   logic [2:0]  i_fmt = '0;
   logic        o_vld;
   logic [31:0] o_word;
   logic [5:0]  o_len;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   sfc_top uut (
      .clk(clk), .rst_n(rst_n), .i_vld(i_vld), .i_sample(i_sample),
      .i_fmt(i_fmt), .o_vld(o_vld), .o_word(o_word), .o_len(o_len));

   function automatic logic [31:0] ref_round(logic [31:0] x, int w);
      longint xs = longint'($signed(x));
      longint q  = (xs + (longint'(1) << (31 - w))) >>> (32 - w);
      longint mx = (longint'(1) << (w - 1)) - 1;
      longint mk = (longint'(1) << w) - 1;
      if (q > mx) q = mx;
      return 32'((q & mk) << (32 - w));
   endfunction

   function automatic logic [31:0] ref_float(logic [31:0] x);
      longint xs = longint'($signed(x));
      longint lim = longint'(1) << 31;
      longint v;
      int e = 0;
      logic [63:0] sv;
      for (int s = 1; s <= 15; s++) begin
         v = xs * (longint'(1) << s);
         if (v >= -lim && v < lim) e = s;
      end
      sv = 64'(xs * (longint'(1) << e));
      return {sv[31:24], 4'(e), 20'd0};
   endfunction

   function automatic logic [31:0] ref_word(logic [31:0] x, int f);
      case (f)
         0: return {x[31:24], 24'd0};
         1: return ref_round(x, 16);
         2: return ref_round(x, 24);
         4: return ref_float(x);
         default: return x;
      endcase
   endfunction

   function automatic logic [5:0] ref_len(int f);
      case (f)
         0: return 6'd8;
         1: return 6'd16;
         2: return 6'd24;
         4: return 6'd12;
         default: return 6'd32;
      endcase
   endfunction

   function automatic string req_of(int f, logic [31:0] x);
      case (f)
         0: return "R4";
         1, 2: return (x[31] == 1'b0 && x[30:16] == 15'h7fff) ? "R6" : "R5";
         4: return (x[31:16] == 16'h0 || x[31:16] == 16'hffff) ? "R9" : "R8";
         default: return "R7";
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act_w, logic [31:0] exp_w,
                        logic [5:0] act_l, logic [5:0] exp_l, logic act_v, logic exp_v);
      n_run++;
      if (act_w !== exp_w || act_l !== exp_l || act_v !== exp_v) begin
         n_fail++;
         $display("FAIL %s: word=%h len=%0d vld=%b expected word=%h len=%0d vld=%b",
                  req, act_w, act_l, act_v, exp_w, exp_l, exp_v);
      end
   endtask

   // one valid sample, result checked one edge later
   task automatic apply(logic [31:0] x, int f);
      i_vld = 1'b1; i_sample = x; i_fmt = 3'(f);
      @(negedge clk);
      check(req_of(f, x), o_word, ref_word(x, f), o_len, ref_len(f), o_vld, 1'b1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : stim
      logic [31:0] lfsr;
      logic [31:0] corner [16];
      corner = '{32'h0000_0000, 32'hffff_ffff, 32'h7fff_ffff, 32'h8000_0000,
                 32'h7fff_8000, 32'h7fff_7fff, 32'h7fff_ff80, 32'h7fff_ff7f,
                 32'h0000_8000, 32'hffff_8000, 32'h0000_7fff, 32'h0001_0000,
                 32'h0000_ffff, 32'hffff_0000, 32'h4000_0000, 32'hc000_0001};
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1", o_word, 32'd0, o_len, 6'd0, o_vld, 1'b0);
      i_vld = 1'b1; i_sample = 32'h1234_5678; i_fmt = 3'd3;
      @(negedge clk);
      check("R1", o_word, 32'd0, o_len, 6'd0, o_vld, 1'b0);
      i_vld = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      // R3: every code, including the ones that alias the 32-bit format
      for (int f = 0; f < 8; f++) begin
         apply(32'h8765_4321, f);
         n_run++;
         if (o_len !== ref_len(f)) begin
            n_fail++;
            $display("FAIL R3: code %0d len=%0d expected %0d", f, o_len, ref_len(f));
         end
      end

      // R5 R6 R8 R9: corner samples in every format
      foreach (corner[k])
         for (int f = 0; f < 5; f++) apply(corner[k], f);

      // R6: sweep the band just below positive full scale
      for (int k = 0; k < 512; k++) begin
         apply(32'h7fff_0000 + 32'(k * 128), 1);
         apply(32'h7fff_ff00 + 32'(k % 256), 2);
      end

      // R9: all small magnitudes around zero
      for (int k = -300; k <= 300; k++) apply(32'(k), 4);

      // R4 R5 R7 R8: pseudo-random sweep, format changes every valid cycle
      lfsr = 32'hace1_2345;
      for (int k = 0; k < 2500; k++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         apply(lfsr >>> (k % 20), k % 5);
      end

      // R2: idle cycles leave word and length unchanged, valid drops
      apply(32'h0f0f_0f0f, 2);
      i_vld = 1'b0; i_sample = 32'hdead_beef; i_fmt = 3'd4;
      @(negedge clk);
      check("R2", o_word, ref_word(32'h0f0f_0f0f, 2), o_len, 6'd24, o_vld, 1'b0);
      @(negedge clk);
      check("R2", o_word, ref_word(32'h0f0f_0f0f, 2), o_len, 6'd24, o_vld, 1'b0);
      apply(32'hdead_beef, 4);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule